// File: doc/BRIEF.md
# Character and Icon Row Pattern Fetch

This block is the refresh engine of a one-line dot-matrix character display with an icon row. It walks the display rows in turn. For each of 14 character positions it reads the stored character code and turns it into the 5-dot pattern for the current pixel row. Codes with the top three bits clear take their pattern from a writable user glyph RAM. All other codes take it from a fixed glyph function, a synthesizable placeholder for a real font. On the last row index the glyph lookup is bypassed: the icon RAM bytes are unpacked, five icon dots per byte, onto the same 70 segment lines.

Clock cycles alternate between display fetch slots and host slots. The host writes the code RAM, the glyph RAM and the icon RAM only in host slots. Display reads happen only in fetch slots, so host writes never disturb a row that is being fetched. A complete 70-bit row is gathered in a buffer. It is moved to the registered segment output in one step, together with the row index, and a one-clock strobe marks the update.

Top module: `glyph_row_fetch`

## Requirements
- R1: After reset `host_slot` is 0 in the first cycle and then toggles every clock. A cycle with `host_slot`=0 is a display fetch slot and a cycle with `host_slot`=1 is a host slot.
- R2: A host write takes effect only when `host_we`=1 in a cycle with `host_slot`=1. `host_tgt` selects the target: 0 is the code RAM (addresses 0..13), 1 is the glyph RAM (addresses 0..255), 2 is the icon RAM (addresses 0..13) and 3 is nothing. A write in a fetch slot is ignored. So is a write to the code or icon RAM at an address of 14 or more.
- R3: `row_stb` pulses for one clock every 28 clocks. On successive pulses `com_out` steps 0,1,…,7 and then wraps to 0. The first pulse after reset carries row 0.
- R4: The dots of character position p (0..13) appear on `seg_out[5p+4:5p]`, with dot bit k on `seg_out[5p+k]`.
- R5: On rows 0..6, a code whose bits 7..5 are all 0 takes its dots from glyph RAM bits 4..0 at address {code[4:0], row}. Glyph RAM bits 7..5 are ignored.
- R6: On rows 0..6, any other code (20h..FFh) shows the placeholder glyph, whose dots are code[6:2] XOR {2'b00, row}.
- R7: On row 7 each position p shows bits 4..0 of icon RAM byte p, whatever the code is. Icon bits 7..5 are ignored.
- R8: `seg_out` and `com_out` change only in a cycle where `row_stb` is 1.
- R9: While reset is held, `seg_out`=0, `com_out`=0 and `row_stb`=0.
- R10: Glyph RAM entries with row field 7 are never shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write request |
| host_tgt | input | 2 | Write target: 0 code, 1 glyph, 2 icon, 3 none |
| host_addr | input | 8 | Write address within the target |
| host_data | input | 8 | Write data |
| host_slot | output | 1 | 1 in host slots, 0 in display fetch slots |
| seg_out | output | 70 | Latched segment pattern of the current row |
| com_out | output | 3 | Row index of `seg_out`; 7 is the icon row |
| row_stb | output | 1 | One-clock pulse when `seg_out`/`com_out` update |

## Verification
The bench loads codes right at the source boundaries: 00h, 1Fh, 20h, 7Fh, 80h and FFh. A design that decoded the wrong code bits would send a code to the wrong glyph source or show the wrong glyph row. Glyph and icon bytes carry junk in bits 7..5, and row-7 glyph entries are all ones. Dot leakage from those bits, or an off-by-one row address, would change the compared segment pattern. Writes made in fetch slots, writes to target 3 and writes to code addresses past the last position must leave the next frame unchanged. A design that checked the wrong slot, or that wrapped the address, would corrupt position 0 or 3. Every strobe is also checked for its 28-cycle spacing and its row order.

// File: rtl/glyph_fetch_pkg.sv
package glyph_fetch_pkg;

  localparam int CODE_W = 8;
  localparam int ROW_W  = 3;
  localparam int DOT_W  = 5;

  typedef enum logic [1:0] {
    TGT_CODE  = 2'd0,
    TGT_GLYPH = 2'd1,
    TGT_ICON  = 2'd2,
    TGT_NONE  = 2'd3
  } host_tgt_e;

  // Placeholder font: a cheap synthesizable stand-in for a mask ROM.
  function automatic logic [DOT_W-1:0] rom_dots(input logic [CODE_W-1:0] code,
                                                input logic [ROW_W-1:0]  row);
    return code[6:2] ^ {2'b00, row};
  endfunction

endpackage

// File: rtl/gf_sp_ram.sv
// Single-port synchronous RAM: a read updates rdata only when en && !we,
// so a write cycle leaves the last read value in place.
module gf_sp_ram #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             en,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end

endmodule

// File: rtl/gf_refresh_seq.sv
// Slot phase and refresh position counters.
module gf_refresh_seq #(
  parameter int NCHAR = 14,
  parameter int ROW_W = 3,
  localparam int CAW  = $clog2(NCHAR)
) (
  input  logic             clk,
  input  logic             rst,
  output logic             phase,
  output logic [CAW-1:0]   ch,
  output logic [ROW_W-1:0] com
);

  localparam logic [CAW-1:0] CH_LAST = CAW'(NCHAR - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= 1'b0;
      ch    <= '0;
      com   <= '0;
    end else begin
      phase <= ~phase;
      if (!phase) begin
        if (ch == CH_LAST) begin
          ch  <= '0;
          com <= com + 1'b1;
        end else begin
          ch <= ch + 1'b1;
        end
      end
    end
  end

  // R1
  slot_alt_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (phase != $past(phase)));

  // R1
  pos_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(phase) |-> ($stable(ch) && $stable(com)));

endmodule

// File: rtl/gf_row_assembler.sv
// Collects one dot group per fetch and latches the whole row at its end.
module gf_row_assembler #(
  parameter int NCHAR = 14,
  parameter int DOT_W = 5,
  parameter int ROW_W = 3,
  localparam int CAW  = $clog2(NCHAR),
  localparam int NSEG = NCHAR * DOT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [CAW-1:0]   ch,
  input  logic [ROW_W-1:0] com,
  input  logic [DOT_W-1:0] dots,
  output logic [NSEG-1:0]  seg_out,
  output logic [ROW_W-1:0] com_out,
  output logic             row_stb
);

  localparam logic [CAW-1:0] CH_LAST = CAW'(NCHAR - 1);

  logic [NSEG-1:0] row_buf;
  logic [NSEG-1:0] merged;

  for (genvar p = 0; p < NCHAR; p++) begin : g_pos
    assign merged[p*DOT_W +: DOT_W] =
      (ch == CAW'(p)) ? dots : row_buf[p*DOT_W +: DOT_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      row_buf <= '0;
      seg_out <= '0;
      com_out <= '0;
      row_stb <= 1'b0;
    end else begin
      row_stb <= 1'b0;
      if (fire) begin
        row_buf <= merged;
        if (ch == CH_LAST) begin
          seg_out <= merged;
          com_out <= com;
          row_stb <= 1'b1;
        end
      end
    end
  end

  // R8
  seg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !row_stb |-> ($stable(seg_out) && $stable(com_out)));

endmodule

// File: rtl/glyph_row_fetch.sv
module glyph_row_fetch
  import glyph_fetch_pkg::*;
#(
  parameter int NCHAR  = 14,
  parameter int NGLYPH = 32,
  parameter int HAW    = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     host_we,
  input  logic [1:0]               host_tgt,
  input  logic [HAW-1:0]           host_addr,
  input  logic [CODE_W-1:0]        host_data,
  output logic                     host_slot,
  output logic [NCHAR*DOT_W-1:0]   seg_out,
  output logic [ROW_W-1:0]         com_out,
  output logic                     row_stb
);

  localparam int CAW   = $clog2(NCHAR);
  localparam int GIDX  = $clog2(NGLYPH);
  localparam int GDEP  = NGLYPH * (1 << ROW_W);
  localparam int GAW   = $clog2(GDEP);
  localparam int GAPW  = $clog2(2 * NCHAR + 1);
  localparam logic [ROW_W-1:0] ICON_ROW = '1;

  // Sequencer
  logic             phase;
  logic [CAW-1:0]   ch;
  logic [ROW_W-1:0] com;
  logic             fetch_en;

  gf_refresh_seq #(.NCHAR(NCHAR), .ROW_W(ROW_W)) u_seq (
    .clk   (clk),
    .rst   (rst),
    .phase (phase),
    .ch    (ch),
    .com   (com)
  );

  assign fetch_en  = ~phase;
  assign host_slot = phase;

  // Host write decode (host slots only)
  logic host_ok, in_char_range;
  logic code_we, glyph_we, icon_we;

  assign host_ok       = phase & host_we;
  assign in_char_range = host_addr < HAW'(NCHAR);
  assign code_we  = host_ok && (host_tgt == TGT_CODE)  && in_char_range;
  assign glyph_we = host_ok && (host_tgt == TGT_GLYPH);
  assign icon_we  = host_ok && (host_tgt == TGT_ICON)  && in_char_range;

  // Stage 1 bookkeeping: position issued on the previous fetch edge
  logic             s1_v;
  logic [CAW-1:0]   s1_ch;
  logic [ROW_W-1:0] s1_com;
  logic [CODE_W-1:0] code_q, icon_q, glyph_q;

  gf_sp_ram #(.WIDTH(CODE_W), .DEPTH(NCHAR)) u_code_ram (
    .clk   (clk),
    .en    (fetch_en | code_we),
    .we    (code_we),
    .addr  (fetch_en ? ch : host_addr[CAW-1:0]),
    .wdata (host_data),
    .rdata (code_q)
  );

  gf_sp_ram #(.WIDTH(CODE_W), .DEPTH(NCHAR)) u_icon_ram (
    .clk   (clk),
    .en    (fetch_en | icon_we),
    .we    (icon_we),
    .addr  (fetch_en ? ch : host_addr[CAW-1:0]),
    .wdata (host_data),
    .rdata (icon_q)
  );

  // Glyph RAM address: code bits form the high field, pixel row the low field.
  logic [GAW-1:0] glyph_fetch_addr;
  assign glyph_fetch_addr = {code_q[GIDX-1:0], s1_com};

  gf_sp_ram #(.WIDTH(CODE_W), .DEPTH(GDEP)) u_glyph_ram (
    .clk   (clk),
    .en    (fetch_en | glyph_we),
    .we    (glyph_we),
    .addr  (fetch_en ? glyph_fetch_addr : host_addr[GAW-1:0]),
    .wdata (host_data),
    .rdata (glyph_q)
  );

  // Stage 2 registers
  logic              s2_v;
  logic [CAW-1:0]    s2_ch;
  logic [ROW_W-1:0]  s2_com;
  logic [CODE_W-1:0] s2_code;
  logic [DOT_W-1:0]  s2_icon;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v    <= 1'b0;
      s1_ch   <= '0;
      s1_com  <= '0;
      s2_v    <= 1'b0;
      s2_ch   <= '0;
      s2_com  <= '0;
      s2_code <= '0;
      s2_icon <= '0;
    end else if (fetch_en) begin
      s1_v    <= 1'b1;
      s1_ch   <= ch;
      s1_com  <= com;
      s2_v    <= s1_v;
      s2_ch   <= s1_ch;
      s2_com  <= s1_com;
      s2_code <= code_q;
      s2_icon <= icon_q[DOT_W-1:0];
    end
  end

  // Source selection
  logic [DOT_W-1:0] dots;
  logic             use_ram;

  assign use_ram = (s2_code[CODE_W-1:GIDX] == '0);

  always_comb begin
    if (s2_com == ICON_ROW)  dots = s2_icon;
    else if (use_ram)        dots = glyph_q[DOT_W-1:0];
    else                     dots = rom_dots(s2_code, s2_com);
  end

  gf_row_assembler #(.NCHAR(NCHAR), .DOT_W(DOT_W), .ROW_W(ROW_W)) u_asm (
    .clk     (clk),
    .rst     (rst),
    .fire    (fetch_en & s2_v),
    .ch      (s2_ch),
    .com     (s2_com),
    .dots    (dots),
    .seg_out (seg_out),
    .com_out (com_out),
    .row_stb (row_stb)
  );

  // Strobe spacing and row order watch
  logic [GAPW-1:0]  gap_cnt;
  logic             stb_seen;
  logic [ROW_W-1:0] last_com;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_cnt  <= '0;
      stb_seen <= 1'b0;
      last_com <= '0;
    end else if (row_stb) begin
      gap_cnt  <= '0;
      stb_seen <= 1'b1;
      last_com <= com_out;
    end else begin
      gap_cnt <= gap_cnt + 1'b1;
    end
  end

  // R3
  stb_gap_chk: assert property (@(posedge clk) disable iff (rst)
    row_stb && stb_seen |-> (gap_cnt == GAPW'(2 * NCHAR - 1)));

  // R3
  com_step_chk: assert property (@(posedge clk) disable iff (rst)
    row_stb && stb_seen |-> (com_out == last_com + 1'b1));

  // R3
  first_row_chk: assert property (@(posedge clk) disable iff (rst)
    row_stb && !stb_seen |-> (com_out == '0));

  // R2
  fetch_slot_wr_chk: assert property (@(posedge clk) disable iff (rst)
    host_slot == 1'b0 |-> !(code_we || glyph_we || icon_we));

  // R9
  reset_out_chk: assert property (@(posedge clk)
    rst |=> (seg_out == '0 && com_out == '0 && !row_stb));

endmodule

// File: tb/glyph_row_fetch_bench.sv
module glyph_row_fetch_bench;

  localparam int NCHAR = 14;
  localparam int NSEG  = NCHAR * 5;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            host_we = 1'b0;
  logic [1:0]      host_tgt = 2'd3;
  logic [7:0]      host_addr = '0;
  logic [7:0]      host_data = '0;
  logic            host_slot;
  logic [NSEG-1:0] seg_out;
  logic [2:0]      com_out;
  logic            row_stb;

  glyph_row_fetch u_glyph_row_fetch (
    .clk(clk), .rst(rst), .host_we(host_we), .host_tgt(host_tgt),
    .host_addr(host_addr), .host_data(host_data), .host_slot(host_slot),
    .seg_out(seg_out), .com_out(com_out), .row_stb(row_stb)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Model of the RAM contents as the host wrote them
  logic [7:0] m_code [NCHAR];
  logic [7:0] m_icon [NCHAR];
  logic [7:0] m_glyph [256];

  logic [NSEG+2:0] sb_q [$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [NSEG-1:0] act, input logic [NSEG-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [NSEG-1:0] exp_row(input int c);
    logic [NSEG-1:0] r;
    logic [4:0] d;
    logic [7:0] cd;
    r = '0;
    for (int p = 0; p < NCHAR; p++) begin
      cd = m_code[p];
      if (c == 7) d = m_icon[p][4:0];                       // R7
      else if (cd[7:5] == 3'b000) d = m_glyph[{cd[4:0], 3'(c)}][4:0]; // R5
      else d = cd[6:2] ^ {2'b00, 3'(c)};                    // R6
      r[p*5 +: 5] = d;                                      // R4
    end
    return r;
  endfunction

  task automatic host_write(input logic [1:0] t, input logic [7:0] a,
                            input logic [7:0] d);
    @(negedge clk);
    while (!host_slot) @(negedge clk);
    host_we = 1'b1; host_tgt = t; host_addr = a; host_data = d;
    @(negedge clk);
    host_we = 1'b0; host_tgt = 2'd3;
    if (t == 2'd0 && a < NCHAR) m_code[a] = d;
    if (t == 2'd2 && a < NCHAR) m_icon[a] = d;
    if (t == 2'd1) m_glyph[a] = d;
  endtask

  task automatic fetch_slot_write(input logic [1:0] t, input logic [7:0] a,
                                  input logic [7:0] d);
    @(negedge clk);
    while (host_slot) @(negedge clk);
    host_we = 1'b1; host_tgt = t; host_addr = a; host_data = d;
    @(negedge clk);
    host_we = 1'b0; host_tgt = 2'd3;
  endtask

  task automatic wait_frame_end();
    @(negedge clk);
    while (!(row_stb && com_out == 3'd7)) @(negedge clk);
  endtask

  // Driver: push one full frame of expected rows into the scoreboard
  task automatic expect_frame();
    wait_frame_end();
    wait_frame_end();
    @(posedge clk);
    for (int c = 0; c < 8; c++) sb_q.push_back({3'(c), exp_row(c)});
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  // Monitor: strobe timing and scoreboard compare
  int  gap = 0;
  bit  seen = 1'b0;
  logic [2:0] prev_com = '0;

  always @(negedge clk) begin
    if (!rst && !done) begin
      if (row_stb) begin
        if (seen) begin
          check(gap == 28, "R3", "strobe spacing", NSEG'(gap), NSEG'(28));
          check(com_out == prev_com + 3'd1, "R3", "row order",
                NSEG'(com_out), NSEG'(prev_com + 3'd1));
        end else begin
          check(com_out == 3'd0, "R3", "first row", NSEG'(com_out), '0);
        end
        if (sb_q.size() != 0) begin
          logic [NSEG+2:0] it;
          it = sb_q.pop_front();
          check(com_out == it[NSEG +: 3], "R4", "row index",
                NSEG'(com_out), NSEG'(it[NSEG +: 3]));
          check(seg_out == it[NSEG-1:0],
                (it[NSEG +: 3] == 3'd7) ? "R7" : "R5/R6", "row pattern",
                seg_out, it[NSEG-1:0]);
        end
        seen = 1'b1;
        prev_com = com_out;
        gap = 1;
      end else begin
        gap++;
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) m_glyph[i] = '0;
    for (int i = 0; i < NCHAR; i++) begin m_code[i] = '0; m_icon[i] = '0; end

    // R9: reset state
    repeat (4) @(negedge clk);
    check(seg_out == '0, "R9", "seg in reset", seg_out, '0);
    check(com_out == '0, "R9", "com in reset", NSEG'(com_out), '0);
    check(!row_stb, "R9", "stb in reset", NSEG'(row_stb), '0);
    rst = 1'b0;

    // R1: slot alternation from release
    for (int i = 0; i < 6; i++) begin
      check(host_slot == 1'(i % 2), "R1", "slot phase",
            NSEG'(host_slot), NSEG'(i % 2));
      @(negedge clk);
    end

    // Frame A: mixed sources, junk upper bits, row-7 entries set (R10)
    for (int g = 0; g < 32; g++)
      for (int r = 0; r < 8; r++)
        host_write(2'd1, 8'(g*8 + r),
                   (r == 7) ? 8'hFF : {3'b101, 5'(g*7 + r*3)});
    for (int p = 0; p < NCHAR; p++) begin
      host_write(2'd0, 8'(p), (p % 2 == 0) ? 8'(p*2) : 8'(8'h20 + p*17));
      host_write(2'd2, 8'(p), 8'hE0 | 8'(p*5 + 3));
    end
    expect_frame();

    // R2: ignored writes (fetch slot, target 3, out-of-range address)
    fetch_slot_write(2'd0, 8'd3, 8'h55);
    fetch_slot_write(2'd2, 8'd0, 8'h1F);
    host_write(2'd3, 8'd0, 8'h99);
    host_write(2'd0, 8'h10, 8'h77);
    host_write(2'd2, 8'h0E, 8'h1F);
    expect_frame();

    // Frame B: code boundaries 00h/1Fh/20h/7Fh/80h/FFh, icons all on/off
    begin
      logic [7:0] codes [NCHAR] = '{8'h00, 8'h1F, 8'h20, 8'h7F, 8'h80, 8'hFF,
                                    8'hE0, 8'h01, 8'h3C, 8'h1E, 8'hA5, 8'h40,
                                    8'h5A, 8'h1F};
      for (int p = 0; p < NCHAR; p++) begin
        host_write(2'd0, 8'(p), codes[p]);
        host_write(2'd2, 8'(p), (p % 2 == 0) ? 8'hFF : 8'hE0);
      end
      for (int r = 0; r < 8; r++) host_write(2'd1, 8'(248 + r), 8'(8'hE0 | (r + 9)));
    end
    expect_frame();

    // R10: rewrite only row-7 glyph entries; the frame stays as modelled
    for (int g = 0; g < 32; g++) host_write(2'd1, 8'(g*8 + 7), 8'h15);
    expect_frame();

    finish_run();
  end

endmodule